// File: doc/BRIEF.md
# Triple-Buffered Frame-Synchronized Serial Receiver

This block receives fixed-width serial elements. A frame-sync pulse marks the first bit of each element, and bits are sampled on the rising edge of the receive clock, most significant bit first. A finished element passes through three stages: the shift stage, a holding buffer and the host data register. It moves forward only when the next stage is free. The host sees a ready flag, reads the data output and pulses a read strobe to release the data register.

Because there are three stages, three elements can wait unread before anything is lost. When a fourth element starts while all three stages are occupied, the element waiting in the shift stage is discarded and a sticky overrun flag is raised. The buffer and the data register keep the oldest unread elements.

A frame sync that arrives before the current element has all its bits raises a separate sticky sync-error flag. It also restarts assembly, and the partial bits are dropped. A clear input resets both sticky flags.

Top module: `serial_rx3`

## Requirements
- R1: After reset, rxReady, overrun and syncErr are 0 and rxData is all zeros.
- R2: An element is the W bits sampled on W consecutive rising edges, starting with the edge at which frameSync is 1. The first bit is the most significant. Elements reach rxData in arrival order with their values intact.
- R3: Let edge E be the edge that samples the final bit of an element, with all stages empty. The element moves to the buffer at edge E+1 and into rxData at edge E+2. rxReady reads 1 from edge E+2 onward.
- R4: hostRd sampled high while rxReady is 1 clears rxReady at that edge. An element waiting in the buffer is copied into rxData at the following edge, which sets rxReady again.
- R5: hostRd sampled while rxReady is 0 has no effect: rxReady stays 0 and rxData is unchanged.
- R6: Three complete elements received with no host read are all held, without overrun. rxData shows the first of them.
- R7: Overrun occurs when frameSync starts a new element while the shift stage holds a complete element, the buffer is full and rxReady is 1. The overrun flag is then set, and the element in the shift stage is discarded. rxData and the buffer keep their contents, and the new element is assembled as usual.
- R8: A host read sampled one edge before the frameSync of the fourth element prevents loss. All four elements are delivered and overrun stays 0.
- R9: frameSync sampled while an element is partly received sets syncErr. The partial bits are discarded and the new element is assembled from that edge.
- R10: overrun and syncErr stay set until flagClr is sampled high, which clears them.
- R11: serData outside a frame is ignored. A frameSync that arrives while no element is in progress raises no sync error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all sampling on rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| serData | input | 1 | Serial data bit |
| frameSync | input | 1 | High on the first bit of an element |
| hostRd | input | 1 | Host read strobe, one cycle |
| flagClr | input | 1 | Clears the sticky overrun and sync-error flags |
| rxData | output | W | Host data register |
| rxReady | output | 1 | rxData holds an unread element |
| overrun | output | 1 | Sticky: an element was discarded |
| syncErr | output | 1 | Sticky: frame sync arrived mid-element |

## Verification
A wrong stage-occupancy bit shows up at the ports in one of two ways. The scoreboard may find an element missing, duplicated or out of order within a few cycles of the next host read. Or overrun may appear one element early or late, compared with the exact fourth-frame-sync boundary. A wrong bit count shifts every following element by one or more bit positions, so the next compared value is wrong. The latency from the final bit to rxReady is checked on exact cycles, and so is the one-edge read deadline before the fourth element.

// File: rtl/serial_rx3_pkg.sv
package serial_rx3_pkg;

  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic shiftEn;  // sample serData into the shift stage
    logic xfer;     // move shift stage into the buffer
    logic copy;     // move buffer into the host data register
  } rxStrobe_t;

endpackage

// File: rtl/serial_rx3_ctrl.sv
module serial_rx3_ctrl
  import serial_rx3_pkg::*;
#(
  parameter int W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameSync,
  input  logic      hostRd,
  input  logic      flagClr,
  output rxStrobe_t strb,
  output logic      rxReady,
  output logic      overrun,
  output logic      syncErr
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic [CW-1:0] bitCnt;
  logic          shiftFull;
  logic          bufFull;

  logic inFrame, lastBit, copyNow, xferNow, lossEvt, syncEvt;

  always_comb begin
    inFrame = (bitCnt != '0);
    lastBit = inFrame && !frameSync && (bitCnt == LAST_IDX);
    copyNow = bufFull && !rxReady;
    xferNow = shiftFull && (!bufFull || copyNow);
    lossEvt = frameSync && shiftFull && !xferNow;
    syncEvt = frameSync && inFrame;
    strb.shiftEn = frameSync || inFrame;
    strb.xfer    = xferNow;
    strb.copy    = copyNow;
  end

  // Bit counter: 0 means idle, otherwise number of bits already taken
  always_ff @(posedge clk) begin
    if (!rstN)          bitCnt <= '0;
    else if (frameSync) bitCnt <= CW'(1);
    else if (lastBit)   bitCnt <= '0;
    else if (inFrame)   bitCnt <= bitCnt + CW'(1);
  end

  // Stage occupancy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftFull <= 1'b0;
      bufFull   <= 1'b0;
      rxReady   <= 1'b0;
    end else begin
      if (lastBit)                shiftFull <= 1'b1;
      else if (xferNow || lossEvt) shiftFull <= 1'b0;

      if (xferNow)      bufFull <= 1'b1;
      else if (copyNow) bufFull <= 1'b0;

      if (copyNow)     rxReady <= 1'b1;
      else if (hostRd) rxReady <= 1'b0;
    end
  end

  // Sticky error flags; a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrun <= 1'b0;
      syncErr <= 1'b0;
    end else begin
      if (lossEvt)      overrun <= 1'b1;
      else if (flagClr) overrun <= 1'b0;

      if (syncEvt)      syncErr <= 1'b1;
      else if (flagClr) syncErr <= 1'b0;
    end
  end

  // R7
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(frameSync && bufFull && rxReady));

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxReady) |-> $past(hostRd));

  // R9
  sync_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncErr) |-> $past(frameSync));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(overrun) || $fell(syncErr)) |-> $past(flagClr));

endmodule

// File: rtl/serial_rx3_dp.sv
module serial_rx3_dp
  import serial_rx3_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          serData,
  input  rxStrobe_t     strb,
  output logic [W-1:0]  dataReg
);

  logic [W-1:0] shiftReg;
  logic [W-1:0] bufReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bufReg   <= '0;
      dataReg  <= '0;
    end else begin
      if (strb.shiftEn) shiftReg <= {shiftReg[W-2:0], serData};
      if (strb.xfer)    bufReg   <= shiftReg;
      if (strb.copy)    dataReg  <= bufReg;
    end
  end

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.copy |=> $stable(dataReg));

  // R7
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.xfer |=> $stable(bufReg));

endmodule

// File: rtl/serial_rx3.sv
module serial_rx3
  import serial_rx3_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serData,
  input  logic         frameSync,
  input  logic         hostRd,
  input  logic         flagClr,
  output logic [W-1:0] rxData,
  output logic         rxReady,
  output logic         overrun,
  output logic         syncErr
);

  rxStrobe_t strb;

  serial_rx3_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .hostRd    (hostRd),
    .flagClr   (flagClr),
    .strb      (strb),
    .rxReady   (rxReady),
    .overrun   (overrun),
    .syncErr   (syncErr)
  );

  serial_rx3_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .serData (serData),
    .strb    (strb),
    .dataReg (rxData)
  );

endmodule

// File: tb/serial_rx3_bench.sv
module serial_rx3_bench;

  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         serData = 1'b0;
  logic         frameSync = 1'b0;
  logic         hostRd = 1'b0;
  logic         flagClr = 1'b0;
  logic [W-1:0] rxData;
  logic         rxReady, overrun, syncErr;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] expQ[$];
  bit    rdEnable = 1'b0;
  bit    rdOnce = 1'b0;
  bit    strayRd = 1'b0;
  string curReq = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx3 #(.W(W)) u_serial_rx3 (
    .clk(clk), .rstN(rstN), .serData(serData), .frameSync(frameSync),
    .hostRd(hostRd), .flagClr(flagClr), .rxData(rxData),
    .rxReady(rxReady), .overrun(overrun), .syncErr(syncErr)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: reads the host register and compares against the queue
  initial begin
    bit onceUsed = 1'b0;
    forever begin
      @(negedge clk);
      if (!rdOnce) onceUsed = 1'b0;
      if (strayRd) begin
        hostRd = 1'b1;
      end else if (rxReady && !hostRd && (rdEnable || (rdOnce && !onceUsed))) begin
        if (rdOnce) onceUsed = 1'b1;
        if (expQ.size() == 0) begin
          check(1'b0, curReq, 32'(rxData), 32'hDEAD);
        end else begin
          logic [W-1:0] e;
          e = expQ.pop_front();
          check(rxData == e, curReq, 32'(rxData), 32'(e));
        end
        hostRd = 1'b1;
      end else begin
        hostRd = 1'b0;
      end
    end
  end

  // Driver: one element, first bit with frameSync, MSB first
  task automatic sendElem(input logic [W-1:0] v, input bit expect_it);
    if (expect_it) expQ.push_back(v);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      frameSync = (i == 0);
      serData   = v[W-1-i];
    end
    @(negedge clk);
    frameSync = 1'b0;
    serData   = 1'b0;
  endtask

  task automatic sendPartial(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frameSync = (i == 0);
      serData   = i[0];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain(input string req);
    curReq = req;
    rdEnable = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (expQ.size() == 0 && !rxReady && !hostRd) break;
    end
    check(expQ.size() == 0, req, 32'(expQ.size()), 0);
    rdEnable = 1'b0;
    idle(2);
  endtask

  task automatic pulseClr();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rxReady == 0, "R1", 32'(rxReady), 0);
    check(overrun == 0, "R1", 32'(overrun), 0);
    check(syncErr == 0, "R1", 32'(syncErr), 0);
    check(rxData == 0, "R1", 32'(rxData), 0);

    // R11 data outside a frame ignored
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); serData = i[0];
    end
    idle(4);
    check(rxReady == 0, "R11", 32'(rxReady), 0);

    // R3 latency from final bit, R2 MSB first, R11 idle frameSync
    sendElem(8'hA5, 1'b0);
    check(rxReady == 0, "R3", 32'(rxReady), 0);
    @(negedge clk);
    check(rxReady == 0, "R3", 32'(rxReady), 0);
    @(negedge clk);
    check(rxReady == 1, "R3", 32'(rxReady), 1);
    check(rxData == 8'hA5, "R2", 32'(rxData), 32'hA5);
    check(syncErr == 0, "R11", 32'(syncErr), 0);
    expQ.push_back(8'hA5);
    drain("R3");

    // R2 several patterns, back-to-back and with gaps
    rdEnable = 1'b1;
    curReq = "R2";
    sendElem(8'h01, 1'b1);
    sendElem(8'h80, 1'b1);
    idle(3);
    sendElem(8'h3C, 1'b1);
    sendElem(8'hFF, 1'b1);
    sendElem(8'h00, 1'b1);
    idle(1);
    sendElem(8'h96, 1'b1);
    drain("R2");

    // R5 read while not ready
    @(posedge clk); strayRd = 1'b1;
    @(posedge clk); strayRd = 1'b0;
    idle(3);
    check(rxReady == 0, "R5", 32'(rxReady), 0);
    check(rxData == 8'h96, "R5", 32'(rxData), 32'h96);

    // R4 read clears ready, buffered element follows next edge
    curReq = "R4";
    sendElem(8'h5A, 1'b1);
    sendElem(8'hC3, 1'b1);
    idle(4);
    @(posedge clk); rdOnce = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(rxReady == 0, "R4", 32'(rxReady), 0);
    @(negedge clk);
    check(rxReady == 1, "R4", 32'(rxReady), 1);
    check(rxData == 8'hC3, "R4", 32'(rxData), 32'hC3);
    rdOnce = 1'b0;
    drain("R4");

    // R6 three held, R7 fourth causes overrun and loses the third
    sendElem(8'h11, 1'b1);
    sendElem(8'h22, 1'b1);
    sendElem(8'h33, 1'b0);
    idle(4);
    check(overrun == 0, "R6", 32'(overrun), 0);
    check(rxReady == 1, "R6", 32'(rxReady), 1);
    check(rxData == 8'h11, "R6", 32'(rxData), 32'h11);
    sendElem(8'h44, 1'b1);
    check(overrun == 1, "R7", 32'(overrun), 1);
    check(rxData == 8'h11, "R7", 32'(rxData), 32'h11);
    drain("R7");
    check(overrun == 1, "R10", 32'(overrun), 1);
    pulseClr();
    check(overrun == 0, "R10", 32'(overrun), 0);

    // R8 read one edge before the fourth frame sync
    curReq = "R8";
    sendElem(8'h5E, 1'b1);
    sendElem(8'h6D, 1'b1);
    sendElem(8'h7C, 1'b1);
    idle(3);
    @(posedge clk); rdOnce = 1'b1;
    @(negedge clk);
    sendElem(8'h8B, 1'b1);
    rdOnce = 1'b0;
    check(overrun == 0, "R8", 32'(overrun), 0);
    drain("R8");

    // R9 frame sync mid-element restarts assembly
    rdEnable = 1'b1;
    curReq = "R9";
    sendPartial(3);
    sendElem(8'hE7, 1'b1);
    check(syncErr == 1, "R9", 32'(syncErr), 1);
    drain("R9");
    check(syncErr == 1, "R10", 32'(syncErr), 1);
    pulseClr();
    check(syncErr == 0, "R10", 32'(syncErr), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule